// File: doc/BRIEF.md
# Operand Effective Address Generator

This block sits between the opcode decoder and the memory-access stage of a small 8-bit accumulator CPU. The decoder hands it an addressing-mode code, the index register and the address of the opcode byte. The block then takes in the operand bytes that follow the opcode, one per cycle over a valid/ready handshake, and produces the 16-bit effective operand address and the total instruction length. For the three-byte bit-test-and-branch form it also produces the relative branch target.

The short modes reach only the bottom of the address space. Page-zero direct and no-offset indexed addresses have a zero high byte. The 8-bit-offset indexed sum keeps its carry, so it can reach 0x01FE. A done strobe marks each finished address. The outputs are registered and hold their values until the next completion.

Top module: `ea_gen`

## Requirements
- R1: Mode code 1 (page-zero direct) consumes one operand byte B. The result is eff_addr = {0x00, B} and instr_len = 2.
- R2: Mode code 2 (full 16-bit address) consumes two operand bytes. The first byte becomes eff_addr[15:8], the second becomes eff_addr[7:0], and instr_len = 3.
- R3: Mode code 0 (index, no offset) consumes no byte. done rises one cycle after the request, byte_ready never rises, eff_addr = {0x00, X} and instr_len = 1.
- R4: Mode code 3 (index plus byte offset) consumes one byte B. eff_addr is the unsigned sum X + B, carried into bit 8, so the largest value is 0x01FE and bits 15..9 are zero. instr_len = 2.
- R5: Mode code 4 (bit-test branch) consumes two bytes. The first byte gives eff_addr = {0x00, byte1}. The second byte is a signed displacement, and br_target = opcode_pc + 3 + sign-extended displacement, modulo 2^16. instr_len = 3. Every other mode reports br_target = 0.
- R6: A byte is consumed on a cycle where byte_valid and byte_ready are both high, at most one per cycle. byte_ready is high only while operand bytes are still owed. A cycle with byte_valid low consumes nothing and stalls the fetch.
- R7: done is high for exactly one cycle, in the cycle after the final operand byte is consumed. eff_addr, br_target and instr_len keep their values until the next completion.
- R8: Mode codes 5, 6 and 7 are not accepted. No fetch starts and done stays low.
- R9: While a fetch is in progress, a new request has no effect. The running fetch completes with its own mode.
- R10: While rst is high and after it falls, done and byte_ready are 0 and eff_addr, br_target and instr_len read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request for a new operand fetch |
| req_mode | input | 3 | Addressing-mode code (0..4 valid) |
| req_index | input | 8 | Index register value |
| req_pc | input | 16 | Address of the opcode byte |
| byte_valid | input | 1 | Operand byte present on byte_data |
| byte_data | input | 8 | Operand byte stream |
| byte_ready | output | 1 | Block accepts an operand byte this cycle |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle completion strobe |
| eff_addr | output | 16 | Effective operand address |
| br_target | output | 16 | Relative branch target (bit-test branch only) |
| instr_len | output | 2 | Instruction length in bytes, opcode included |

## Verification
The bench uses an index of 0xFF and an offset of 0xFF. A design that dropped the carry would give 0x00FE instead of 0x01FE. It checks branch displacements that are both negative and wrap past 0xFFFF, which exposes missing sign extension or a wrong "+3" base. It leaves gaps in byte_valid in the middle of a fetch, to catch a design that counts cycles rather than handshakes and raises done early. It also raises a request in the middle of a fetch and an illegal mode code: a design that honoured either would report a wrong length or an extra done pulse.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int MODE_W = 3;
  localparam int LEN_W  = 2;
  localparam int CNT_W  = 2;

  localparam logic [MODE_W-1:0] M_IDX0 = 3'd0;
  localparam logic [MODE_W-1:0] M_DIR  = 3'd1;
  localparam logic [MODE_W-1:0] M_EXT  = 3'd2;
  localparam logic [MODE_W-1:0] M_IDX8 = 3'd3;
  localparam logic [MODE_W-1:0] M_BTB  = 3'd4;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return m <= M_BTB;
  endfunction

  function automatic logic [CNT_W-1:0] operand_bytes(input logic [MODE_W-1:0] m);
    case (m)
      M_DIR, M_IDX8: return CNT_W'(1);
      M_EXT, M_BTB:  return CNT_W'(2);
      default:       return CNT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [BYTE_W-1:0] req_index,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              busy,
  output logic              finish,
  output logic [MODE_W-1:0] sel_mode,
  output logic [BYTE_W-1:0] sel_index,
  output logic [ADDR_W-1:0] sel_pc,
  output logic [BYTE_W-1:0] first_byte,
  output logic [BYTE_W-1:0] last_byte
);
  logic              busy_q;
  logic [MODE_W-1:0] mode_q;
  logic [BYTE_W-1:0] idx_q;
  logic [ADDR_W-1:0] pc_q;
  logic [BYTE_W-1:0] first_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  need_q;

  logic start, accept, last;

  assign start  = !busy_q && req_valid && mode_legal(req_mode);
  assign accept = busy_q && byte_valid;
  assign last   = accept && (cnt_q == need_q - CNT_W'(1));
  assign finish = (start && operand_bytes(req_mode) == '0) || last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      mode_q  <= '0;
      idx_q   <= '0;
      pc_q    <= '0;
      first_q <= '0;
      cnt_q   <= '0;
      need_q  <= '0;
    end else begin
      if (start) begin
        mode_q <= req_mode;
        idx_q  <= req_index;
        pc_q   <= req_pc;
        need_q <= operand_bytes(req_mode);
        cnt_q  <= '0;
        busy_q <= (operand_bytes(req_mode) != '0);
      end else if (accept) begin
        if (cnt_q == '0) first_q <= byte_data;
        cnt_q <= cnt_q + CNT_W'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign byte_ready = busy_q;
  assign busy       = busy_q;
  assign sel_mode   = busy_q ? mode_q : req_mode;
  assign sel_index  = busy_q ? idx_q  : req_index;
  assign sel_pc     = busy_q ? pc_q   : req_pc;
  assign first_byte = first_q;
  assign last_byte  = byte_data;

  // R9: a fetch keeps its mode until its last byte, whatever arrives on req_*
  assert_mode_held_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> (busy_q && $stable(mode_q)));

  // R9: a fetch only begins in response to a request
  assert_start_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(req_valid));

  // R8: an illegal code never launches a fetch
  assert_illegal_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && req_valid && !mode_legal(req_mode)) |=> !busy_q);
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [BYTE_W-1:0] index,
  input  logic [ADDR_W-1:0] pc,
  input  logic [BYTE_W-1:0] first_byte,
  input  logic [BYTE_W-1:0] last_byte,
  output logic [ADDR_W-1:0] eff,
  output logic [ADDR_W-1:0] target,
  output logic [LEN_W-1:0]  len
);
  localparam int SUM_W = BYTE_W + 1;
  localparam logic [ADDR_W-1:0] BTB_SIZE = ADDR_W'(3);

  logic [SUM_W-1:0]  idx_sum;
  logic [ADDR_W-1:0] disp_ext;

  assign idx_sum  = SUM_W'(index) + SUM_W'(last_byte);
  assign disp_ext = {{(ADDR_W-BYTE_W){last_byte[BYTE_W-1]}}, last_byte};

  always_comb begin
    eff    = '0;
    target = '0;
    case (mode)
      M_DIR:  eff = ADDR_W'(last_byte);
      M_EXT:  eff = {first_byte, last_byte};
      M_IDX8: eff = ADDR_W'(idx_sum);
      M_BTB: begin
        eff    = ADDR_W'(first_byte);
        target = pc + BTB_SIZE + disp_ext;
      end
      default: eff = ADDR_W'(index);
    endcase
    len = LEN_W'(operand_bytes(mode)) + LEN_W'(1);
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic [7:0]        req_index,
  input  logic [15:0]       req_pc,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic              busy,
  output logic              done,
  output logic [15:0]       eff_addr,
  output logic [15:0]       br_target,
  output logic [1:0]        instr_len
);
  logic              finish;
  logic [MODE_W-1:0] sel_mode;
  logic [BYTE_W-1:0] sel_index, first_b, last_b;
  logic [ADDR_W-1:0] sel_pc, eff_c, tgt_c;
  logic [LEN_W-1:0]  len_c;
  logic [MODE_W-1:0] done_mode_q;

  ea_seq u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_mode(req_mode), .req_index(req_index), .req_pc(req_pc),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .busy(busy), .finish(finish),
    .sel_mode(sel_mode), .sel_index(sel_index), .sel_pc(sel_pc),
    .first_byte(first_b), .last_byte(last_b)
  );

  ea_calc u_calc (
    .mode(sel_mode), .index(sel_index), .pc(sel_pc),
    .first_byte(first_b), .last_byte(last_b),
    .eff(eff_c), .target(tgt_c), .len(len_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      eff_addr    <= '0;
      br_target   <= '0;
      instr_len   <= '0;
      done_mode_q <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        eff_addr    <= eff_c;
        br_target   <= tgt_c;
        instr_len   <= len_c;
        done_mode_q <= sel_mode;
      end
    end
  end

  // R1: short modes never produce a nonzero high byte
  assert_short_hi_R1: assert property (@(posedge clk) disable iff (rst)
    (done && (done_mode_q == M_DIR || done_mode_q == M_IDX0 || done_mode_q == M_BTB))
      |-> (eff_addr[15:8] == 8'h00));

  // R4: index plus offset stays within 0x0000..0x01FE
  assert_idx8_range_R4: assert property (@(posedge clk) disable iff (rst)
    (done && done_mode_q == M_IDX8) |-> (eff_addr <= 16'h01FE));

  // R7: done follows a consumed final byte or a zero-byte request
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(byte_valid && byte_ready) || $past(req_valid)));

  // R7: outputs hold between completions
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(eff_addr) && $stable(instr_len)));

  // R8: a completion always reports a length of 1..3
  assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (instr_len != 2'd0));
endmodule

// File: tb/ea_gen_tb_top.sv
`timescale 1ns/1ps
module ea_gen_tb_top;
  logic clk = 0, rst = 1;
  logic req_valid = 0, byte_valid = 0;
  logic [2:0] req_mode = 0;
  logic [7:0] req_index = 0, byte_data = 0;
  logic [15:0] req_pc = 0;
  logic byte_ready, busy, done;
  logic [15:0] eff_addr, br_target;
  logic [1:0] instr_len;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  ea_gen dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_index(req_index), .req_pc(req_pc), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .busy(busy), .done(done),
    .eff_addr(eff_addr), .br_target(br_target), .instr_len(instr_len)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // issue request at a negedge, return at the following negedge with req dropped
  task automatic issue(input logic [2:0] m, input logic [7:0] x, input logic [15:0] pc);
    @(negedge clk);
    req_valid = 1; req_mode = m; req_index = x; req_pc = pc;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic feed(input logic [7:0] b, input int gap);
    for (int i = 0; i < gap; i++) @(negedge clk);
    byte_valid = 1; byte_data = b;
    @(negedge clk);
    byte_valid = 0;
  endtask

  task automatic t_reset();
    chk("R10 done", 16'(done), 16'h0);
    chk("R10 ready", 16'(byte_ready), 16'h0);
    chk("R10 eff", eff_addr, 16'h0);
    chk("R10 len", 16'(instr_len), 16'h0);
  endtask

  task automatic t_direct();
    issue(3'd1, 8'h33, 16'h2000);
    chk("R6 ready while owed", 16'(byte_ready), 16'h1);
    feed(8'h7F, 0);
    chk("R1 done", 16'(done), 16'h1);
    chk("R1 eff", eff_addr, 16'h007F);
    chk("R1 len", 16'(instr_len), 16'd2);
    chk("R5 br zero for direct", br_target, 16'h0);
    @(negedge clk);
    chk("R7 single pulse", 16'(done), 16'h0);
    chk("R7 eff held", eff_addr, 16'h007F);
  endtask

  task automatic t_extended_stall();
    issue(3'd2, 8'h00, 16'h0100);
    feed(8'h12, 2);
    chk("R6 no done mid fetch", 16'(done), 16'h0);
    @(negedge clk);
    chk("R6 stall no done", 16'(done), 16'h0);
    feed(8'h34, 1);
    chk("R2 done", 16'(done), 16'h1);
    chk("R2 eff", eff_addr, 16'h1234);
    chk("R2 len", 16'(instr_len), 16'd3);
  endtask

  task automatic t_index0();
    issue(3'd0, 8'hA5, 16'h4000);
    chk("R3 done", 16'(done), 16'h1);
    chk("R3 ready low", 16'(byte_ready), 16'h0);
    chk("R3 eff", eff_addr, 16'h00A5);
    chk("R3 len", 16'(instr_len), 16'd1);
  endtask

  task automatic t_index8(input logic [7:0] x, input logic [7:0] b, input logic [15:0] exp);
    issue(3'd3, x, 16'h0);
    feed(b, 0);
    chk("R4 eff", eff_addr, exp);
    chk("R4 len", 16'(instr_len), 16'd2);
  endtask

  task automatic t_btb(input logic [15:0] pc, input logic [7:0] a, input logic [7:0] d,
                       input logic [15:0] exp_t);
    issue(3'd4, 8'h55, pc);
    feed(a, 0);
    feed(d, 1);
    chk("R5 done", 16'(done), 16'h1);
    chk("R5 eff", eff_addr, {8'h00, a});
    chk("R5 target", br_target, exp_t);
    chk("R5 len", 16'(instr_len), 16'd3);
  endtask

  task automatic t_busy_ignore();
    issue(3'd2, 8'h00, 16'h0);
    feed(8'hBE, 0);
    req_valid = 1; req_mode = 3'd0; req_index = 8'h11;
    @(negedge clk);
    req_valid = 0;
    chk("R9 no done from ignored req", 16'(done), 16'h0);
    chk("R9 still fetching", 16'(byte_ready), 16'h1);
    feed(8'hEF, 0);
    chk("R9 eff", eff_addr, 16'hBEEF);
    chk("R9 len", 16'(instr_len), 16'd3);
  endtask

  task automatic t_illegal();
    issue(3'd6, 8'h22, 16'h0);
    chk("R8 ready low", 16'(byte_ready), 16'h0);
    chk("R8 done low", 16'(done), 16'h0);
    chk("R8 len held", 16'(instr_len), 16'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_extended_stall();
    t_index0();
    t_index8(8'hFF, 8'hFF, 16'h01FE);
    t_index8(8'h10, 8'h20, 16'h0030);
    t_btb(16'h1000, 8'h40, 8'hFE, 16'h1001);
    t_btb(16'hFFFE, 8'h80, 8'h05, 16'h0006);
    t_btb(16'h0000, 8'h01, 8'h80, 16'hFF83);
    t_busy_ignore();
    t_illegal();
    report();
  end

  initial begin
    #(5.0 * 100000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule